// File: doc/BRIEF.md
# Scatter-List Offset Locator and Segment Walker

This block takes one command's scatter/gather descriptor table, finds which descriptor holds a given starting byte offset, and turns the rest of the table into a list of (address, length) segments for a data mover. Each descriptor carries a 64-bit buffer address and a size word. The size word holds a zero-based byte count in its low field, so the descriptor's real length is one more than that value. The first segment is cut to start at the offset's position inside its descriptor. Every later descriptor is passed on whole.

A command starts with a single-cycle `start`. It carries the command options word, the command table base address and the starting offset. The number of descriptors comes from a field of the options word. The block reports where the descriptor table sits in memory. The descriptors themselves are fetched elsewhere and are presented in table order on a valid/ready input stream. Segments leave on a valid/ready output stream. Back-pressure on the segment stream stalls descriptor intake, because only one segment is held at a time. At the end, `done` pulses with an error flag and the total number of bytes emitted. The data mover uses that total to update its transferred-byte count.

Top module: `prdt_walker`

## Requirements
- R1: From the cycle after an accepted `start`, `table_addr` equals `cmd_tbl_base + 0x80` (modulo 2^64) and holds that value until the next accepted `start`.
- R2: The descriptor count is `cmd_opts[31:16]`, and the other option bits are ignored. A count of zero consumes no descriptor and emits no segment. It ends with `done` while `err` = 1 and `total_bytes` = 0.
- R3: A descriptor's length is `desc_size_word[21:0] + 1`. Bits 31:22 of the size word have no effect on any output.
- R4: The located descriptor is the lowest index i for which offset <= (sum of lengths of descriptors 0..i-1) + length(i). With pos = offset minus that prior sum, the first segment is (addr(i) + pos, length(i) - pos). When the offset lands exactly on the end of descriptor i, this segment has length 0.
- R5: Descriptors before the located one produce no segment. Every descriptor after it is emitted whole, with its own address and length, in table order.
- R6: If no descriptor satisfies R4, no segment is emitted and `done` comes with `err` = 1 and `total_bytes` = 0. All descriptors of the command are still consumed.
- R7: Exactly as many descriptors are accepted (`desc_valid && desc_ready`) as the count, and `desc_ready` is low whenever `busy` is low.
- R8: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr` and `seg_len` stay unchanged in the next cycle.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse that comes after the last segment handshake, with `busy` and `seg_valid` low. `total_bytes` is the sum of all emitted segment lengths and is held until the next accepted `start`. `err` is 0 on a successful walk.
- R10: A `start` while `busy` is high is ignored. The walk in progress, its segments, its total and `table_addr` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (accepted only while idle) |
| cmd_opts | input | 32 | Command options word; bits 31:16 give the descriptor count |
| cmd_tbl_base | input | 64 | Command table base address |
| xfer_offset | input | 32 | Starting byte offset into the scatter list |
| table_addr | output | 64 | Address of the descriptor table (base + 0x80) |
| busy | output | 1 | A walk is in progress |
| desc_valid | input | 1 | Descriptor stream valid |
| desc_ready | output | 1 | Descriptor stream ready |
| desc_addr | input | 64 | Descriptor buffer address |
| desc_size_word | input | 32 | Descriptor size word; bits 21:0 are the zero-based byte count |
| seg_valid | output | 1 | Segment stream valid |
| seg_ready | input | 1 | Segment stream ready |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | 23 | Segment length in bytes |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Offset not located, or count zero; valid with `done` |
| total_bytes | output | 39 | Sum of emitted segment lengths |

## Verification
The assertions assume the descriptor producer keeps `desc_addr` and `desc_size_word` steady while a descriptor waits on `desc_ready`. They also assume the sum of a table's lengths fits in `total_bytes`, so the located position always fits a segment length. The bench meets both conditions. Its tables have at most a few descriptors, it holds every descriptor until the handshake, and its offsets are 32-bit values against tables that can exceed them. The segment consumer's ready is driven from a pseudo-random sequence, and descriptor arrival has random gaps. Together these exercise stalls on both streams without ever changing a descriptor before it is accepted.

// File: rtl/prdt_walk_pkg.sv
package prdt_walk_pkg;
  localparam int unsigned DEF_ADDR_W   = 64;
  localparam int unsigned DEF_SIZE_W   = 22;
  localparam int unsigned DEF_OFF_W    = 32;
  localparam int unsigned DEF_CNT_W    = 16;
  localparam int unsigned DEF_CNT_LSB  = 16;
  localparam int unsigned DEF_TBL_GAP  = 128;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_SCAN,
    WK_EMIT,
    WK_FINISH
  } walk_state_e;
endpackage

// File: rtl/prdt_entry_eval.sv
// Combinational evaluation of one descriptor: true length, locate test,
// and the segment it yields (trimmed when locating, whole otherwise).
module prdt_entry_eval #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SIZE_W = 22,
  parameter int unsigned TOT_W  = 39
) (
  input  logic [31:0]        size_word,
  input  logic [ADDR_W-1:0]  ent_addr,
  input  logic [TOT_W-1:0]   sum_before,
  input  logic [TOT_W-1:0]   offset,
  input  logic               locate,
  output logic [SIZE_W:0]    ent_len,
  output logic               hit,
  output logic [ADDR_W-1:0]  seg_addr,
  output logic [SIZE_W:0]    seg_len
);
  localparam int unsigned LEN_W = SIZE_W + 1;

  logic [TOT_W-1:0] reach;
  logic [TOT_W-1:0] pos_full;
  logic [LEN_W-1:0] pos;
  logic             unused_hi;

  always_comb begin
    ent_len  = {1'b0, size_word[SIZE_W-1:0]} + LEN_W'(1);
    reach    = sum_before + TOT_W'(ent_len);
    hit      = (offset <= reach);
    pos_full = locate ? (offset - sum_before) : '0;
    pos      = pos_full[LEN_W-1:0];
    seg_addr = ent_addr + ADDR_W'(pos);
    seg_len  = ent_len - pos;
  end

  assign unused_hi = ^{size_word[31:SIZE_W], pos_full[TOT_W-1:LEN_W]};
endmodule

// File: rtl/prdt_entry_counter.sv
// Index of the descriptor being consumed and a flag for the final one.
module prdt_entry_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             is_last
);
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= idx_q + CNT_W'(1);
    end
  end

  assign is_last = (idx_q == (limit - CNT_W'(1)));
endmodule

// File: rtl/prdt_seg_slot.sv
// Single output register for the segment stream.
module prdt_seg_slot #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEN_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_len
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_len   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= load_addr;
      out_len   <= load_len;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prdt_walker.sv
module prdt_walker
  import prdt_walk_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned SIZE_W  = DEF_SIZE_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned CNT_LSB = DEF_CNT_LSB,
  parameter int unsigned TBL_GAP = DEF_TBL_GAP,
  localparam int unsigned LEN_W  = SIZE_W + 1,
  localparam int unsigned TOT_W  = LEN_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       cmd_opts,
  input  logic [ADDR_W-1:0] cmd_tbl_base,
  input  logic [OFF_W-1:0]  xfer_offset,
  output logic [ADDR_W-1:0] table_addr,
  output logic              busy,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [31:0]       desc_size_word,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              done,
  output logic              err,
  output logic [TOT_W-1:0]  total_bytes
);
  walk_state_e       state_q;
  logic [CNT_W-1:0]  limit_q;
  logic [TOT_W-1:0]  sum_q;
  logic [TOT_W-1:0]  off_q;
  logic [TOT_W-1:0]  tot_q;
  logic [ADDR_W-1:0] tbl_q;
  logic              err_q;
  logic              done_q;

  logic              accept_start;
  logic [CNT_W-1:0]  new_count;
  logic              seg_free;
  logic              desc_fire;
  logic              locate;
  logic              seg_load;
  logic              is_last;
  logic [LEN_W-1:0]  ent_len;
  logic              hit;
  logic [ADDR_W-1:0] ev_addr;
  logic [LEN_W-1:0]  ev_len;
  logic              unused_opts;

  assign accept_start = start && (state_q == WK_IDLE);
  assign new_count    = cmd_opts[CNT_LSB +: CNT_W];
  assign seg_free     = !seg_valid || seg_ready;
  assign locate       = (state_q == WK_SCAN);
  assign desc_ready   = locate || ((state_q == WK_EMIT) && seg_free);
  assign desc_fire    = desc_valid && desc_ready;
  assign seg_load     = desc_fire && ((state_q == WK_EMIT) || hit);

  generate
    if (CNT_LSB > 0) begin : g_low_opts
      if (CNT_LSB + CNT_W < 32) begin : g_both
        assign unused_opts = ^{cmd_opts[31:CNT_LSB+CNT_W], cmd_opts[CNT_LSB-1:0]};
      end else begin : g_low_only
        assign unused_opts = ^cmd_opts[CNT_LSB-1:0];
      end
    end else if (CNT_W < 32) begin : g_high_opts
      assign unused_opts = ^cmd_opts[31:CNT_W];
    end else begin : g_no_opts
      assign unused_opts = 1'b0;
    end
  endgenerate

  prdt_entry_eval #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TOT_W(TOT_W)
  ) u_eval (
    .size_word (desc_size_word),
    .ent_addr  (desc_addr),
    .sum_before(sum_q),
    .offset    (off_q),
    .locate    (locate),
    .ent_len   (ent_len),
    .hit       (hit),
    .seg_addr  (ev_addr),
    .seg_len   (ev_len)
  );

  prdt_entry_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept_start),
    .step   (desc_fire),
    .limit  (limit_q),
    .is_last(is_last)
  );

  prdt_seg_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (seg_load),
    .load_addr(ev_addr),
    .load_len (ev_len),
    .out_ready(seg_ready),
    .out_valid(seg_valid),
    .out_addr (seg_addr),
    .out_len  (seg_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      limit_q <= '0;
      sum_q   <= '0;
      off_q   <= '0;
      tot_q   <= '0;
      tbl_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        WK_IDLE: begin
          if (start) begin
            tbl_q   <= cmd_tbl_base + ADDR_W'(TBL_GAP);
            off_q   <= TOT_W'(xfer_offset);
            sum_q   <= '0;
            tot_q   <= '0;
            limit_q <= new_count;
            err_q   <= (new_count == '0);
            state_q <= (new_count == '0) ? WK_FINISH : WK_SCAN;
          end
        end
        WK_SCAN: begin
          if (desc_fire) begin
            if (hit) begin
              tot_q   <= tot_q + TOT_W'(ev_len);
              state_q <= is_last ? WK_FINISH : WK_EMIT;
            end else begin
              sum_q <= sum_q + TOT_W'(ent_len);
              if (is_last) begin
                err_q   <= 1'b1;
                state_q <= WK_FINISH;
              end
            end
          end
        end
        WK_EMIT: begin
          if (desc_fire) begin
            tot_q <= tot_q + TOT_W'(ev_len);
            if (is_last) state_q <= WK_FINISH;
          end
        end
        WK_FINISH: begin
          if (!seg_valid) begin
            done_q  <= 1'b1;
            state_q <= WK_IDLE;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign table_addr  = tbl_q;
  assign busy        = (state_q != WK_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign total_bytes = tot_q;
endmodule

// File: rtl/prdt_walker_checks.sv
module prdt_walker_checks #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LEN_W  = 23,
  parameter int unsigned TOT_W  = 39
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic [ADDR_W-1:0] table_addr,
  input logic              desc_ready,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [ADDR_W-1:0] seg_addr,
  input logic [LEN_W-1:0]  seg_len,
  input logic              done,
  input logic              err,
  input logic [TOT_W-1:0]  total_bytes
);
  logic [15:0] seg_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || (start && !busy)) begin
      seg_cnt <= '0;
    end else if (seg_valid && seg_ready) begin
      seg_cnt <= seg_cnt + 16'd1;
    end
  end

  a_r8_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

  a_r7_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_drained: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !seg_valid);

  a_r6_err_no_segments: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> seg_cnt == 16'd0 && total_bytes == '0);

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(table_addr));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !seg_valid);
endmodule

bind prdt_walker prdt_walker_checks #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TOT_W(TOT_W)
) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .table_addr (table_addr),
  .desc_ready (desc_ready),
  .seg_valid  (seg_valid),
  .seg_ready  (seg_ready),
  .seg_addr   (seg_addr),
  .seg_len    (seg_len),
  .done       (done),
  .err        (err),
  .total_bytes(total_bytes)
);

// File: tb/prdt_walker_bench.sv
module prdt_walker_bench;
  localparam int LEN_W = 23;
  localparam int TOT_W = 39;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       cmd_opts = '0;
  logic [63:0]       cmd_tbl_base = '0;
  logic [31:0]       xfer_offset = '0;
  logic [63:0]       table_addr;
  logic              busy;
  logic              desc_valid = 1'b0;
  logic              desc_ready;
  logic [63:0]       desc_addr = '0;
  logic [31:0]       desc_size_word = '0;
  logic              seg_valid;
  logic              seg_ready = 1'b0;
  logic [63:0]       seg_addr;
  logic [LEN_W-1:0]  seg_len;
  logic              done;
  logic              err;
  logic [TOT_W-1:0]  total_bytes;

  always #2 clk = ~clk;

  prdt_walker u_prdt_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_opts(cmd_opts),
    .cmd_tbl_base(cmd_tbl_base), .xfer_offset(xfer_offset),
    .table_addr(table_addr), .busy(busy),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_size_word(desc_size_word),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len),
    .done(done), .err(err), .total_bytes(total_bytes)
  );

  int n_checks = 0;
  int n_errors = 0;

  logic [63:0] e_addr [0:15];
  logic [31:0] e_word [0:15];

  logic [63:0]      qa[$];
  logic [LEN_W-1:0] ql[$];
  string            qt[$];

  logic [15:0] lf_mon = 16'hACE1;
  logic [15:0] lf_drv = 16'h1D37;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Scoreboard model built from the requirements.
  task automatic model(input int n, input logic [31:0] off,
                       output bit m_err, output logic [TOT_W-1:0] m_tot);
    longint unsigned sum, len, pos;
    bit found;
    sum = 0; found = 0; m_err = 0; m_tot = '0;
    if (n == 0) begin
      m_err = 1;
      return;
    end
    for (int i = 0; i < n; i++) begin
      len = longint'(e_word[i] & 32'h003F_FFFF) + 1;
      if (!found) begin
        if (longint'(off) <= sum + len) begin
          found = 1;
          pos = longint'(off) - sum;
          qa.push_back(e_addr[i] + pos);
          ql.push_back(LEN_W'(len - pos));
          qt.push_back("R4 first segment");
          m_tot = m_tot + TOT_W'(len - pos);
        end else begin
          sum = sum + len;
        end
      end else begin
        qa.push_back(e_addr[i]);
        ql.push_back(LEN_W'(len));
        qt.push_back("R5 whole segment");
        m_tot = m_tot + TOT_W'(len);
      end
    end
    if (!found) m_err = 1;
  endtask

  // Segment monitor: random back-pressure, compares on handshake.
  bit               hold_pend = 0;
  logic [63:0]      hold_a;
  logic [LEN_W-1:0] hold_l;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(seg_valid, "R8 valid held under stall", 64'(seg_valid), 64'd1);
        chk(seg_addr == hold_a && seg_len == hold_l, "R8 segment held under stall",
            seg_addr, hold_a);
      end
      seg_ready = lf_mon[0] | lf_mon[1];
      lf_mon = lfsr_step(lf_mon);
      if (seg_valid && seg_ready) begin
        hold_pend = 0;
        if (qa.size() == 0) begin
          chk(0, "R5 unexpected segment", seg_addr, 64'd0);
        end else begin
          logic [63:0] ea;
          logic [LEN_W-1:0] el;
          string et;
          ea = qa.pop_front(); el = ql.pop_front(); et = qt.pop_front();
          chk(seg_addr == ea, {et, " address"}, seg_addr, ea);
          chk(seg_len == el, {et, " length"}, 64'(seg_len), 64'(el));
        end
      end else begin
        hold_pend = seg_valid;
        hold_a = seg_addr;
        hold_l = seg_len;
      end
    end
  end

  task automatic run_case(input string name, input int n, input logic [31:0] off,
                          input logic [63:0] base, input int poke);
    bit m_err;
    logic [TOT_W-1:0] m_tot;
    int acc_n;
    bit acc;
    model(n, off, m_err, m_tot);
    @(negedge clk);
    start = 1'b1;
    cmd_opts = {n[15:0], 16'hC3A5};
    cmd_tbl_base = base;
    xfer_offset = off;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R9 busy after start ", name}, 64'(busy), 64'd1);
    chk(table_addr == base + 64'h80, {"R1 table address ", name}, table_addr, base + 64'h80);
    acc_n = 0;
    for (int i = 0; i < n; i++) begin
      if (lf_drv[0] & lf_drv[1]) @(negedge clk);
      lf_drv = lfsr_step(lf_drv);
      desc_valid = 1'b1;
      desc_addr = e_addr[i];
      desc_size_word = e_word[i];
      if (i == poke) begin
        start = 1'b1;
        cmd_opts = 32'h0001_0000;
        cmd_tbl_base = ~base;
        xfer_offset = 32'd0;
      end
      do begin
        #1 acc = desc_ready;
        @(negedge clk);
        start = 1'b0;
      end while (!acc);
      acc_n++;
      desc_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(err == m_err, {(n == 0) ? "R2 error on empty list " : "R6 error flag ", name},
        64'(err), 64'(m_err));
    chk(total_bytes == m_tot, {"R9 total bytes ", name}, 64'(total_bytes), 64'(m_tot));
    chk(qa.size() == 0, {"R5 all segments seen ", name}, 64'(qa.size()), 64'd0);
    chk(acc_n == n, {(n == 0) ? "R2 no descriptor taken " : "R7 descriptors taken ", name},
        64'(acc_n), 64'(n));
    chk(!seg_valid && !busy, {"R9 drained at done ", name}, 64'({seg_valid, busy}), 64'd0);
    if (poke >= 0)
      chk(table_addr == base + 64'h80, {"R10 start ignored ", name}, table_addr, base + 64'h80);
    @(negedge clk);
    chk(total_bytes == m_tot, {"R9 total held ", name}, 64'(total_bytes), 64'(m_tot));
    qa.delete(); ql.delete(); qt.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !seg_valid && !done && !desc_ready, "R9 reset state",
        64'({busy, seg_valid, done, desc_ready}), 64'd0);

    // Three entries of 0x100, 0x200, 0x40 bytes.
    e_addr[0] = 64'h0000_1000_0000_0000; e_word[0] = 32'h0000_00FF;
    e_addr[1] = 64'h0000_2000_0000_0400; e_word[1] = 32'h0000_01FF;
    e_addr[2] = 64'h0000_3000_0000_0800; e_word[2] = 32'h0000_003F;
    e_addr[3] = 64'h0000_4000_0000_0C00; e_word[3] = 32'h0000_0FFF;
    e_addr[4] = 64'hFFFF_FFFF_FFFF_FF00; e_word[4] = 32'h0000_0010;
    run_case("offset zero", 3, 32'd0, 64'h0000_0000_8000_0000, -1);
    run_case("offset inside second", 4, 32'h150, 64'h0000_0000_9000_0040, -1);
    run_case("offset at end of first", 3, 32'h100, 64'h0000_0000_A000_0000, -1);
    run_case("offset past table", 3, 32'h1000, 64'h0000_0000_B000_0000, -1);
    run_case("empty list", 0, 32'd0, 64'hFFFF_FFFF_FFFF_FFC0, -1);
    run_case("start while busy", 5, 32'h20, 64'h0000_0001_0000_0000, 2);

    // R3: flag bits above the size field ignored; maximum length.
    e_addr[0] = 64'h0000_5000_0000_0000; e_word[0] = 32'hFFFF_FFFF;
    e_addr[1] = 64'h0000_6000_0000_0000; e_word[1] = 32'h8000_0007;
    run_case("R3 size field mask", 2, 32'h003F_FFF0, 64'h0000_0000_C000_0000, -1);
    run_case("R3 max length whole", 2, 32'd0, 64'h0000_0000_D000_0000, -1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule